// File: doc/BRIEF.md
# Time-of-Day Calendar Counter with Alarm

This block holds a wall-clock time and a calendar date as byte registers (seconds, minutes, hours, day of week, day of month, month, year) and moves them forward by one second each time the one-pulse-per-second input arrives. Each advance runs inside an update window of fixed length. While the window is open a status bit is high. The new time is written only when the window closes, so any read taken while the status bit is low still has the whole window ahead of it before a field can change.

The three alarm bytes for seconds, minutes and hours are compared with the freshly advanced time. An alarm byte whose two top bits are both set acts as a wildcard. Three mode inputs select binary or BCD counting, 12- or 24-hour hours, and a hold that freezes all updating so that software can load a consistent time. A byte-wide register port gives combinational reads and clocked writes.

Top module: `tod_calendar`

## Requirements
- R1: Register map: 0 second, 1 alarm second, 2 minute, 3 alarm minute, 4 hour, 5 alarm hour, 6 day of week, 7 day of month, 8 month, 9 year. Reads are combinational. A write lands at the next clock edge. Address 10 reads {busy_o, 7'b0}. Addresses 11 to 15 read 0x00, and writes to addresses 10 to 15 change nothing.
- R2: The cycle after tick_i is sampled high with hold_i low and no window open, busy_o rises and stays high for exactly UPD_CYCLES cycles. The time bytes do not change while it is high, and a tick that arrives during the window is ignored.
- R3: When the window closes, busy_o falls. In that same cycle the time has advanced by one second and upd_done_o is high for exactly one cycle.
- R4: With bin_mode_i=0, every time field counts in BCD (for example, 0x09 goes to 0x10, and 0x59 goes to 0x00 with a carry).
- R5: With bin_mode_i=1, every time field counts in plain binary (for example, 0x09 goes to 0x0A, and 0x3B goes to 0x00 with a carry).
- R6: With h24_mode_i=1, hours run from 0 to 23, and 23 goes to 0 with a carry into the date.
- R7: With h24_mode_i=0, hour bit 7 is the PM flag and the low bits run 12, 1, ..., 11. Going from 11 to 12 toggles PM, and going from 11 PM to 12 AM carries into the date.
- R8: Day of month wraps to 1 after the length of the month (30 for months 4, 6, 9 and 11; 31 for the other months; 29 for February when the year value is divisible by 4, otherwise 28). Month 12 wraps to 1 and increments the year. Year 99 wraps to 0. Day of week runs 1 to 7 and wraps from 7 to 1.
- R9: With hold_i high, a tick starts no window. Raising hold_i while a window is open closes it the next cycle with no upd_done_o pulse and no change to the time.
- R10: alarm_o pulses together with upd_done_o when the advanced second, minute and hour each equal their alarm byte. An alarm byte of 0xC0 or above matches any value. Alarm bytes are never changed by updates.
- R11: After reset, all bytes are 0x00 except day of week, day of month and month, which are 0x01. busy_o, upd_done_o and alarm_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-per-second pulse from the time base |
| hold_i | input | 1 | Freeze updating (set/stop) |
| bin_mode_i | input | 1 | 1 = binary fields, 0 = BCD fields |
| h24_mode_i | input | 1 | 1 = 24-hour hours, 0 = 12-hour hours with PM in bit 7 |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data |
| busy_o | output | 1 | Update window open |
| upd_done_o | output | 1 | One-cycle pulse at window close |
| alarm_o | output | 1 | One-cycle alarm match pulse |

## Verification
A tick sampled at edge E0 opens the window, so busy_o reads high after E0 and after each of the next UPD_CYCLES-1 edges. It reads low after edge E0+UPD_CYCLES, which is also where upd_done_o, alarm_o and the new time bytes first appear. The update task samples at every falling edge from E0 onward and checks the window, the unchanged seconds, the pulse and its one-cycle width at those exact offsets. Register reads are combinational and are sampled one nanosecond after the address is set. A write is checked at the falling edge after the edge that stores it.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned NUM_REGS = 10;
  localparam int unsigned ADDR_W   = 4;

  localparam logic [ADDR_W-1:0] A_SEC   = 4'd0;
  localparam logic [ADDR_W-1:0] A_ASEC  = 4'd1;
  localparam logic [ADDR_W-1:0] A_MIN   = 4'd2;
  localparam logic [ADDR_W-1:0] A_AMIN  = 4'd3;
  localparam logic [ADDR_W-1:0] A_HOUR  = 4'd4;
  localparam logic [ADDR_W-1:0] A_AHOUR = 4'd5;
  localparam logic [ADDR_W-1:0] A_WDAY  = 4'd6;
  localparam logic [ADDR_W-1:0] A_MDAY  = 4'd7;
  localparam logic [ADDR_W-1:0] A_MON   = 4'd8;
  localparam logic [ADDR_W-1:0] A_YEAR  = 4'd9;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd10;

  // bit i set: byte i is a time field loaded by the update
  localparam logic [NUM_REGS-1:0] TIME_MASK = 10'b11_1101_0101;

  typedef logic [NUM_REGS-1:0][7:0] regs_t;

  function automatic logic [7:0] to_bin(input logic [7:0] v, input logic bin);
    return bin ? v : (8'(v[7:4]) * 8'd10 + 8'(v[3:0]));
  endfunction

  function automatic logic [7:0] from_bin(input logic [7:0] v, input logic bin);
    logic [7:0] tens;
    logic [7:0] ones;
    tens = v / 8'd10;
    ones = v % 8'd10;
    return bin ? v : {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] year);
    logic [7:0] len;
    case (mon)
      8'd2:                      len = (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   len = 8'd30;
      default:                   len = 8'd31;
    endcase
    return len;
  endfunction

  function automatic logic alarm_eq(input logic [7:0] alarm, input logic [7:0] value);
    return (alarm[7:6] == 2'b11) || (alarm == value);
  endfunction
endpackage

// File: rtl/tod_sequencer.sv
module tod_sequencer #(
  parameter int unsigned UPD_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hold_i,
  output logic busy_o,
  output logic fire_o,
  output logic done_o
);
  localparam int unsigned CW = (UPD_CYCLES > 1) ? $clog2(UPD_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(UPD_CYCLES - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          start;

  assign start  = tick_i && !hold_i && !busy_q;
  assign fire_o = busy_q && !hold_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fire_o;
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q && (hold_i || fire_o)) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  assert_window_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (32'(cnt_q) < UPD_CYCLES));
  assert_hold_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !busy_q) |=> !busy_q);
  assert_hold_aborts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && busy_q) |=> (!busy_q && !done_q));
endmodule

// File: rtl/tod_advance.sv
module tod_advance
  import tod_pkg::*;
(
  input  regs_t cur_i,
  input  logic  bin_i,
  input  logic  h24_i,
  output regs_t nxt_o
);
  logic [7:0] s, m, hr, wd, md, mo, yr, len;
  logic [7:0] ns, nm, nh, nwd, nmd, nmo, nyr, hout;
  logic       pm, npm, c_s, c_m, c_h, c_d, c_mo;

  always_comb begin
    s  = to_bin(cur_i[A_SEC], bin_i);
    m  = to_bin(cur_i[A_MIN], bin_i);
    hr = h24_i ? to_bin(cur_i[A_HOUR], bin_i) : to_bin({1'b0, cur_i[A_HOUR][6:0]}, bin_i);
    pm = !h24_i && cur_i[A_HOUR][7];
    wd = to_bin(cur_i[A_WDAY], bin_i);
    md = to_bin(cur_i[A_MDAY], bin_i);
    mo = to_bin(cur_i[A_MON], bin_i);
    yr = to_bin(cur_i[A_YEAR], bin_i);

    c_s = (s >= 8'd59);
    ns  = c_s ? 8'd0 : s + 8'd1;
    c_m = c_s && (m >= 8'd59);
    nm  = c_s ? (c_m ? 8'd0 : m + 8'd1) : m;

    nh  = hr;
    npm = pm;
    c_h = 1'b0;
    if (c_m) begin
      if (h24_i) begin
        c_h = (hr >= 8'd23);
        nh  = c_h ? 8'd0 : hr + 8'd1;
      end else if (hr >= 8'd12) begin
        nh = 8'd1;
      end else if (hr == 8'd11) begin
        nh  = 8'd12;
        npm = !pm;
        c_h = pm;
      end else begin
        nh = hr + 8'd1;
      end
    end

    len  = month_len(mo, yr);
    c_d  = c_h && (md >= len);
    nmd  = c_h ? (c_d ? 8'd1 : md + 8'd1) : md;
    nwd  = c_h ? ((wd >= 8'd7) ? 8'd1 : wd + 8'd1) : wd;
    c_mo = c_d && (mo >= 8'd12);
    nmo  = c_d ? (c_mo ? 8'd1 : mo + 8'd1) : mo;
    nyr  = c_mo ? ((yr >= 8'd99) ? 8'd0 : yr + 8'd1) : yr;

    hout = from_bin(nh, bin_i);
    if (!h24_i) hout = {npm, hout[6:0]};

    nxt_o          = cur_i;
    nxt_o[A_SEC]   = from_bin(ns, bin_i);
    nxt_o[A_MIN]   = from_bin(nm, bin_i);
    nxt_o[A_HOUR]  = hout;
    nxt_o[A_WDAY]  = from_bin(nwd, bin_i);
    nxt_o[A_MDAY]  = from_bin(nmd, bin_i);
    nxt_o[A_MON]   = from_bin(nmo, bin_i);
    nxt_o[A_YEAR]  = from_bin(nyr, bin_i);
  end
endmodule

// File: rtl/tod_regfile.sv
module tod_regfile
  import tod_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              load_i,
  input  regs_t             nxt_i,
  output regs_t             regs_o
);
  regs_t regs_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] RST_VAL =
      ((i == int'(A_WDAY)) || (i == int'(A_MDAY)) || (i == int'(A_MON))) ? 8'd1 : 8'd0;
    logic wr_hit;
    assign wr_hit = wr_en_i && (addr_i == ADDR_W'(i));

    if (TIME_MASK[i]) begin : g_time
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     regs_q[i] <= RST_VAL;
        else if (wr_hit) regs_q[i] <= wdata_i;
        else if (load_i) regs_q[i] <= nxt_i[i];
      end
    end else begin : g_alarm
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     regs_q[i] <= RST_VAL;
        else if (wr_hit) regs_q[i] <= wdata_i;
      end
    end
  end

  assign regs_o = regs_q;

  assert_time_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !load_i) |=> $stable(regs_q));
  assert_alarm_kept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && (addr_i == A_ASEC)) |=> $stable(regs_q[A_ASEC]));
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
  import tod_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  fire_i,
  input  regs_t regs_i,
  input  regs_t nxt_i,
  output logic  alarm_o
);
  logic hit;
  logic alarm_q;

  assign hit = alarm_eq(regs_i[A_ASEC],  nxt_i[A_SEC]) &&
               alarm_eq(regs_i[A_AMIN],  nxt_i[A_MIN]) &&
               alarm_eq(regs_i[A_AHOUR], nxt_i[A_HOUR]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alarm_q <= 1'b0;
    else         alarm_q <= fire_i && hit;
  end

  assign alarm_o = alarm_q;

  assert_alarm_once_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_q |=> !alarm_q);
endmodule

// File: rtl/tod_calendar.sv
module tod_calendar
  import tod_pkg::*;
#(
  parameter int unsigned UPD_CYCLES = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       hold_i,
  input  logic       bin_mode_i,
  input  logic       h24_mode_i,
  input  logic       wr_en_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       busy_o,
  output logic       upd_done_o,
  output logic       alarm_o
);
  regs_t regs;
  regs_t nxt;
  logic  fire;

  tod_sequencer #(.UPD_CYCLES(UPD_CYCLES)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .hold_i (hold_i),
    .busy_o (busy_o),
    .fire_o (fire),
    .done_o (upd_done_o)
  );

  tod_advance u_adv (
    .cur_i (regs),
    .bin_i (bin_mode_i),
    .h24_i (h24_mode_i),
    .nxt_o (nxt)
  );

  tod_regfile u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .load_i  (fire),
    .nxt_i   (nxt),
    .regs_o  (regs)
  );

  tod_alarm u_alarm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .regs_i  (regs),
    .nxt_i   (nxt),
    .alarm_o (alarm_o)
  );

  always_comb begin
    if (32'(addr_i) < NUM_REGS) rdata_o = regs[addr_i];
    else if (addr_i == A_STAT)  rdata_o = {busy_o, 7'b0};
    else                        rdata_o = 8'h00;
  end

  assert_done_closes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_done_o |-> (!busy_o && $past(busy_o)));
  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_done_o |=> !upd_done_o);
  assert_alarm_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> upd_done_o);
endmodule

// File: tb/tod_calendar_bench.sv
module tod_calendar_bench;
  localparam int unsigned U = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       hold_i = 1'b0;
  logic       bin_mode_i = 1'b0;
  logic       h24_mode_i = 1'b1;
  logic       wr_en_i = 1'b0;
  logic [3:0] addr_i = 4'd0;
  logic [7:0] wdata_i = 8'd0;
  logic [7:0] rdata_o;
  logic       busy_o, upd_done_o, alarm_o;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  tod_calendar #(.UPD_CYCLES(U)) u_tod_calendar (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .hold_i(hold_i),
    .bin_mode_i(bin_mode_i), .h24_mode_i(h24_mode_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .busy_o(busy_o),
    .upd_done_o(upd_done_o), .alarm_o(alarm_o)
  );

  always @(negedge clk_i) if (upd_done_o) done_cnt++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr_i = a; #1; d = rdata_o;
    @(negedge clk_i);
  endtask

  task automatic set_time(input logic [7:0] s, m, h, wd, md, mo, yr);
    wr(4'd0, s); wr(4'd2, m); wr(4'd4, h); wr(4'd6, wd);
    wr(4'd7, md); wr(4'd8, mo); wr(4'd9, yr);
  endtask

  task automatic expect_time(input string req, input logic [7:0] s, m, h, wd, md, mo, yr);
    logic [7:0] v [7];
    logic [7:0] e [7];
    logic [3:0] a [7];
    a = '{4'd0, 4'd2, 4'd4, 4'd6, 4'd7, 4'd8, 4'd9};
    e = '{s, m, h, wd, md, mo, yr};
    for (int i = 0; i < 7; i++) rd(a[i], v[i]);
    check(req, {v[0], v[1], v[2], v[3]}, {e[0], e[1], e[2], e[3]});
    check(req, {v[4], v[5], v[6]}, {e[4], e[5], e[6]});
  endtask

  // Tick, check window shape and pulse timing; return alarm state at close
  task automatic run_update(input string req, output logic alarm_seen);
    logic [7:0] s0;
    bit ok;
    addr_i = 4'd0; #1; s0 = rdata_o;
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
    ok = 1;
    for (int k = 0; k < U; k++) begin
      if (!busy_o || upd_done_o || alarm_o || rdata_o !== s0) ok = 0;
      if (k == 2) tick_i = 1'b1;  // extra tick inside the window: ignored
      @(negedge clk_i);
      tick_i = 1'b0;
    end
    check({req, " R2 window"}, ok, 1);
    check({req, " R3 close"}, {busy_o, upd_done_o}, 2'b01);
    alarm_seen = alarm_o;
    @(negedge clk_i);
    check({req, " R3 one-cycle"}, {busy_o, upd_done_o}, 2'b00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R11 status", {busy_o, upd_done_o, alarm_o}, 3'b000);
    expect_time("R11 time", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    rd(4'd1, d); check("R11 alarm sec", d, 8'h00);
    rd(4'd5, d); check("R11 alarm hour", d, 8'h00);
  endtask

  task automatic t_map();
    logic [7:0] d;
    for (int i = 0; i < 10; i++) wr(4'(i), 8'(8'h20 + i));
    for (int i = 0; i < 10; i++) begin
      rd(4'(i), d);
      check("R1 map", d, 8'(8'h20 + i));
    end
    wr(4'd10, 8'hFF); wr(4'd12, 8'hFF); wr(4'd15, 8'hFF);
    rd(4'd10, d); check("R1 status idle", d, 8'h00);
    rd(4'd12, d); check("R1 unmapped", d, 8'h00);
    rd(4'd15, d); check("R1 unmapped", d, 8'h00);
    rd(4'd0, d);  check("R1 no alias", d, 8'h20);
    // status bit 7 mirrors the open window
    addr_i = 4'd10; tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0; #1;
    check("R1 status busy", rdata_o, 8'h80);
    repeat (U + 1) @(negedge clk_i);
  endtask

  task automatic t_bcd();
    logic a;
    bin_mode_i = 1'b0; h24_mode_i = 1'b1;
    wr(4'd1, 8'hC0); wr(4'd3, 8'hC0); wr(4'd5, 8'hC0);
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    run_update("R4 R6 R8 bcd", a);
    expect_time("R6 R8 full rollover", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    set_time(8'h09, 8'h19, 8'h09, 8'h03, 8'h15, 8'h06, 8'h42);
    run_update("R4 digit", a);
    expect_time("R4 bcd digit carry", 8'h10, 8'h19, 8'h09, 8'h03, 8'h15, 8'h06, 8'h42);
  endtask

  task automatic t_binary();
    logic a;
    bin_mode_i = 1'b1; h24_mode_i = 1'b1;
    set_time(8'h09, 8'h05, 8'h05, 8'h02, 8'h0A, 8'h03, 8'h10);
    run_update("R5 digit", a);
    expect_time("R5 binary digit", 8'h0A, 8'h05, 8'h05, 8'h02, 8'h0A, 8'h03, 8'h10);
    set_time(8'h3B, 8'h3B, 8'h17, 8'h03, 8'd28, 8'd2, 8'd4);
    run_update("R5 R8 leap", a);
    expect_time("R8 leap feb 28", 8'h00, 8'h00, 8'h00, 8'h04, 8'd29, 8'd2, 8'd4);
    set_time(8'h3B, 8'h3B, 8'h17, 8'h07, 8'd29, 8'd2, 8'd4);
    run_update("R8 leap end", a);
    expect_time("R8 leap feb 29", 8'h00, 8'h00, 8'h00, 8'h01, 8'd1, 8'd3, 8'd4);
    set_time(8'h3B, 8'h3B, 8'h17, 8'h01, 8'd28, 8'd2, 8'd5);
    run_update("R8 common", a);
    expect_time("R8 common feb", 8'h00, 8'h00, 8'h00, 8'h02, 8'd1, 8'd3, 8'd5);
    set_time(8'h3B, 8'h3B, 8'h17, 8'h01, 8'd30, 8'd4, 8'd5);
    run_update("R8 april", a);
    expect_time("R8 april 30", 8'h00, 8'h00, 8'h00, 8'h02, 8'd1, 8'd5, 8'd5);
  endtask

  task automatic t_12h();
    logic a;
    bin_mode_i = 1'b0; h24_mode_i = 1'b0;
    set_time(8'h59, 8'h59, 8'h11, 8'h02, 8'h05, 8'h03, 8'h21);
    run_update("R7 am", a);
    expect_time("R7 11am to 12pm", 8'h00, 8'h00, 8'h92, 8'h02, 8'h05, 8'h03, 8'h21);
    set_time(8'h59, 8'h59, 8'h92, 8'h02, 8'h05, 8'h03, 8'h21);
    run_update("R7 noon", a);
    expect_time("R7 12pm to 1pm", 8'h00, 8'h00, 8'h81, 8'h02, 8'h05, 8'h03, 8'h21);
    set_time(8'h59, 8'h59, 8'h91, 8'h02, 8'h05, 8'h03, 8'h21);
    run_update("R7 midnight", a);
    expect_time("R7 11pm to 12am", 8'h00, 8'h00, 8'h12, 8'h03, 8'h06, 8'h03, 8'h21);
    set_time(8'h59, 8'h59, 8'h12, 8'h03, 8'h06, 8'h03, 8'h21);
    run_update("R7 12am", a);
    expect_time("R7 12am to 1am", 8'h00, 8'h00, 8'h01, 8'h03, 8'h06, 8'h03, 8'h21);
  endtask

  task automatic t_hold();
    int d0;
    bin_mode_i = 1'b0; h24_mode_i = 1'b1;
    set_time(8'h30, 8'h10, 8'h08, 8'h04, 8'h12, 8'h07, 8'h33);
    hold_i = 1'b1;
    d0 = done_cnt;
    tick_i = 1'b1; @(negedge clk_i); tick_i = 1'b0;
    check("R9 hold no window", busy_o, 1'b0);
    repeat (U + 2) @(negedge clk_i);
    check("R9 hold no pulse", done_cnt - d0, 0);
    expect_time("R9 hold frozen", 8'h30, 8'h10, 8'h08, 8'h04, 8'h12, 8'h07, 8'h33);
    hold_i = 1'b0;
    tick_i = 1'b1; @(negedge clk_i); tick_i = 1'b0;
    repeat (2) @(negedge clk_i);
    hold_i = 1'b1;
    @(negedge clk_i);
    check("R9 abort closes", busy_o, 1'b0);
    repeat (U + 2) @(negedge clk_i);
    hold_i = 1'b0;
    check("R9 abort no pulse", done_cnt - d0, 0);
    expect_time("R9 abort frozen", 8'h30, 8'h10, 8'h08, 8'h04, 8'h12, 8'h07, 8'h33);
  endtask

  task automatic t_alarm();
    logic a;
    logic [7:0] d;
    bin_mode_i = 1'b0; h24_mode_i = 1'b1;
    wr(4'd1, 8'h00); wr(4'd3, 8'hC5); wr(4'd5, 8'h05);
    set_time(8'h59, 8'h10, 8'h05, 8'h01, 8'h01, 8'h01, 8'h00);
    run_update("R10 hit", a);
    check("R10 alarm match wildcard min", a, 1'b1);
    run_update("R10 miss", a);
    check("R10 no alarm on second mismatch", a, 1'b0);
    wr(4'd1, 8'hFF);
    set_time(8'h20, 8'h10, 8'h04, 8'h01, 8'h01, 8'h01, 8'h00);
    run_update("R10 hour miss", a);
    check("R10 no alarm on hour mismatch", a, 1'b0);
    rd(4'd1, d); check("R10 alarm sec kept", d, 8'hFF);
    rd(4'd3, d); check("R10 alarm min kept", d, 8'hC5);
    rd(4'd5, d); check("R10 alarm hour kept", d, 8'h05);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_map();
    t_bcd();
    t_binary();
    t_12h();
    t_hold();
    t_alarm();
    finish_run();
  end
endmodule